// File: doc/BRIEF.md
# Single Write-Port Issue Stall Controller

This block sits at the front of a five-stage pipeline (fetch, decode/register read, execute, memory, writeback). Two instruction classes finish at different depths: a register-to-register arithmetic instruction skips the memory stage and writes the register file in its fourth stage. A load writes in its fifth stage. The register file has a single write port, so two instructions of different lengths can both try to write it in the same cycle.

Each cycle the fetch side presents the class of the next instruction. The controller keeps a short shift register that holds the future cycles already claimed on the write port, one entry per cycle. It accepts the instruction only when the cycle that instruction will write in is still free. Otherwise it holds the instruction back, which puts a bubble into the pipeline. Every cycle it also reports which class, if any, owns the write port.

Top module: `wbk_port_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wb_owner_o` is idle (2'b00). Any booking made before reset never appears on `wb_owner_o`.
- R2: Class codes on `req_cls_i` are 2'b00 none, 2'b01 ALU and 2'b10 load. An ALU request accepted in cycle t, with `accept_o` high in that same cycle, shows `wb_owner_o` = 2'b01 in cycle t+3.
- R3: A load request accepted in cycle t shows `wb_owner_o` = 2'b10 in cycle t+4.
- R4: An ALU request in the cycle directly after an accepted load is held with `accept_o` low. When presented again unchanged, it is accepted one cycle later and writes in cycle t+5, where t is the load's cycle.
- R5: No two accepted instructions claim the same write cycle. Every accepted instruction appears on `wb_owner_o` exactly in its own write cycle, whatever the mix of classes.
- R6: A request of 2'b00 or the reserved code 2'b11 is never accepted and books no write cycle.
- R7: Back-to-back requests of one class are each accepted in consecutive cycles, and their writes follow on consecutive cycles.
- R8: A load presented in the cycle directly after an accepted ALU instruction is accepted at once. Its write follows the ALU write with one idle cycle in between.
- R9: `wb_owner_o` is idle in every cycle that no accepted instruction claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_cls_i | input | 2 | Class of the instruction waiting to issue (00 none, 01 ALU, 10 load, 11 reserved) |
| accept_o | output | 1 | The presented instruction issues in this cycle |
| wb_owner_o | output | 2 | Class of the instruction writing the register file this cycle (00 idle) |

## Verification
The properties assume that a requester whose instruction was refused keeps presenting the same class until it sees `accept_o`. They also assume that no latency relation other than load = ALU + 1 is in force when the back-to-back stall property applies. The stimulus keeps to the hold rule in every directed scenario. The mixed-stream scenario replays a refused class unchanged on the next cycle and only draws a fresh class after an acceptance or an empty cycle. Reset is applied at least once while write cycles are still booked, so that the clearing of pending claims is exercised.

// File: rtl/wbk_pkg.sv
package wbk_pkg;

  // Instruction class presented at issue and reported as write-port owner
  typedef enum logic [1:0] {
    WB_IDLE = 2'b00,
    WB_ALU  = 2'b01,
    WB_LOAD = 2'b10,
    WB_RSVD = 2'b11
  } wb_cls_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wbk_slot_ring.sv
// Write-cycle reservation ring: entry k names the class that writes k cycles from now.
module wbk_slot_ring #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    book_en,
  input  logic [IDX_W-1:0]        book_idx,
  input  wbk_pkg::wb_cls_e        book_cls,
  output logic [DEPTH-1:0][1:0]   slots_o
);
  import wbk_pkg::*;

  logic [DEPTH-1:0][1:0] slot_q;
  logic [DEPTH-1:0][1:0] slot_d;
  logic                  ring_en;

  // The ring advances every cycle; enable kept explicit
  assign ring_en = 1'b1;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_comb begin
        if (k == DEPTH - 1) begin
          slot_d[k] = WB_IDLE;
        end else begin
          slot_d[k] = slot_q[(k + 1) % DEPTH];
        end
        if (book_en && (book_idx == IDX_W'(k))) begin
          slot_d[k] = book_cls;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q[k] <= WB_IDLE;
        end else if (ring_en) begin
          slot_q[k] <= slot_d[k];
        end
      end
    end
  endgenerate

  assign slots_o = slot_q;

endmodule

// File: rtl/wbk_issue_gate.sv
// Decides whether the presented class may issue, and which ring entry it books.
module wbk_issue_gate #(
  parameter int unsigned ALU_LAT = 3,
  parameter int unsigned LD_LAT  = 4,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [1:0]              req_cls,
  input  logic [DEPTH-1:0][1:0]   slots,
  output logic                    accept,
  output logic                    book_en,
  output logic [IDX_W-1:0]        book_idx,
  output wbk_pkg::wb_cls_e        book_cls
);
  import wbk_pkg::*;

  logic             is_alu;
  logic             is_load;
  logic             valid_cls;
  logic [IDX_W-1:0] target;
  logic             target_busy;

  assign is_alu    = (req_cls == WB_ALU);
  assign is_load   = (req_cls == WB_LOAD);
  assign valid_cls = is_alu | is_load;

  // Cycles from issue to writeback for the presented class
  assign target = is_load ? IDX_W'(LD_LAT) : IDX_W'(ALU_LAT);

  // Entry "target" of the ring is the write cycle this instruction needs;
  // a target equal to DEPTH lies beyond every booking and is always free.
  always_comb begin
    target_busy = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((target == IDX_W'(k)) && (slots[k] != WB_IDLE)) begin
        target_busy = 1'b1;
      end
    end
  end

  assign accept   = valid_cls & ~target_busy;
  assign book_en  = accept;
  // The ring shifts at the same edge that books, so store one entry closer
  assign book_idx = target - IDX_W'(1);
  assign book_cls = is_load ? WB_LOAD : WB_ALU;

endmodule

// File: rtl/wbk_port_arbiter.sv
module wbk_port_arbiter #(
  parameter int unsigned ALU_LAT = 3,
  parameter int unsigned LD_LAT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_cls_i,
  output logic       accept_o,
  output logic [1:0] wb_owner_o
);
  import wbk_pkg::*;

  localparam int unsigned DEPTH = max_u(ALU_LAT, LD_LAT);
  localparam int unsigned IDX_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][1:0] slots;
  logic                  book_en;
  logic [IDX_W-1:0]      book_idx;
  wb_cls_e               book_cls;

  wbk_issue_gate #(
    .ALU_LAT (ALU_LAT),
    .LD_LAT  (LD_LAT),
    .DEPTH   (DEPTH),
    .IDX_W   (IDX_W)
  ) u_gate (
    .req_cls  (req_cls_i),
    .slots    (slots),
    .accept   (accept_o),
    .book_en  (book_en),
    .book_idx (book_idx),
    .book_cls (book_cls)
  );

  wbk_slot_ring #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .book_en  (book_en),
    .book_idx (book_idx),
    .book_cls (book_cls),
    .slots_o  (slots)
  );

  // Entry 0 holds the class writing in the current cycle
  assign wb_owner_o = slots[0];

endmodule

// File: rtl/wbk_port_arbiter_chk.sv
module wbk_port_arbiter_chk #(
  parameter int unsigned ALU_LAT = 3,
  parameter int unsigned LD_LAT  = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_cls_i,
  input logic       accept_o,
  input logic [1:0] wb_owner_o
);
  localparam int unsigned HIST  = (ALU_LAT > LD_LAT ? ALU_LAT : LD_LAT) + 1;
  localparam int unsigned CNT_W = $clog2(HIST + 1);

  // Cycles since reset release, saturating, so $past never reaches into reset
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != CNT_W'(HIST)) begin
      age_q <= age_q + CNT_W'(1);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> wb_owner_o == 2'b00);

  p_alu_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && req_cls_i == 2'b01) |-> ##ALU_LAT (wb_owner_o == 2'b01));

  p_load_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && req_cls_i == 2'b10) |-> ##LD_LAT (wb_owner_o == 2'b10));

  p_alu_behind_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((LD_LAT == ALU_LAT + 1) && age_q != '0 && req_cls_i == 2'b01 &&
     $past(accept_o && req_cls_i == 2'b10)) |-> !accept_o);

  p_invalid_rejected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cls_i == 2'b00 || req_cls_i == 2'b11) |-> !accept_o);

  p_alu_owner_sourced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= CNT_W'(ALU_LAT) && wb_owner_o == 2'b01) |->
      $past(accept_o && req_cls_i == 2'b01, ALU_LAT));

  p_load_owner_sourced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= CNT_W'(LD_LAT) && wb_owner_o == 2'b10) |->
      $past(accept_o && req_cls_i == 2'b10, LD_LAT));

  p_owner_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_owner_o != 2'b11);

endmodule

bind wbk_port_arbiter wbk_port_arbiter_chk #(
  .ALU_LAT (ALU_LAT),
  .LD_LAT  (LD_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_cls_i  (req_cls_i),
  .accept_o   (accept_o),
  .wb_owner_o (wb_owner_o)
);

// File: tb/wbk_port_arbiter_bench.sv
`timescale 1ns/1ps
module wbk_port_arbiter_bench;
  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_ALU  = 2'b01;
  localparam logic [1:0] C_LD   = 2'b10;
  localparam logic [1:0] C_RSV  = 2'b11;

  logic       clk;
  logic       rst_n;
  logic [1:0] req;
  logic       accept;
  logic [1:0] owner;

  int n_checks;
  int n_fails;
  bit finished;

  wbk_port_arbiter u_wbk_port_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_cls_i  (req),
    .accept_o   (accept),
    .wb_owner_o (owner)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string rq, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // One cycle: present class, then sample accept and owner mid-cycle
  task automatic step(input logic [1:0] c, input logic ea, input logic [1:0] eo,
                      input string rq);
    @(negedge clk);
    req = c;
    #1;
    chk(32'(accept), 32'(ea), rq, "accept");
    chk(32'(owner), 32'(eo), rq, "owner");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = C_NONE;
    #1;
    chk(32'(owner), 32'(C_NONE), "R1", "owner in reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(C_NONE, 1'b0, C_NONE, "R1");
    // book a load, then reset before it reaches writeback
    step(C_LD, 1'b1, C_NONE, "R1");
    do_reset();
    for (int i = 0; i < 6; i++) step(C_NONE, 1'b0, C_NONE, "R1");
  endtask

  task automatic t_alu_single();
    step(C_ALU,  1'b1, C_NONE, "R2");
    step(C_NONE, 1'b0, C_NONE, "R2");
    step(C_NONE, 1'b0, C_NONE, "R2");
    step(C_NONE, 1'b0, C_ALU,  "R2");
    step(C_NONE, 1'b0, C_NONE, "R2");
  endtask

  task automatic t_load_single();
    step(C_LD,   1'b1, C_NONE, "R3");
    for (int i = 0; i < 3; i++) step(C_NONE, 1'b0, C_NONE, "R3");
    step(C_NONE, 1'b0, C_LD,   "R3");
    step(C_NONE, 1'b0, C_NONE, "R3");
  endtask

  task automatic t_alu_after_load();
    step(C_LD,   1'b1, C_NONE, "R4");
    step(C_ALU,  1'b0, C_NONE, "R4");
    step(C_ALU,  1'b1, C_NONE, "R4");
    step(C_NONE, 1'b0, C_NONE, "R4");
    step(C_NONE, 1'b0, C_LD,   "R4");
    step(C_NONE, 1'b0, C_ALU,  "R4");
    step(C_NONE, 1'b0, C_NONE, "R4");
  endtask

  task automatic t_ignored();
    step(C_RSV,  1'b0, C_NONE, "R6");
    step(C_NONE, 1'b0, C_NONE, "R6");
    for (int i = 0; i < 4; i++) step(C_NONE, 1'b0, C_NONE, "R6");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 3; i++) step(C_LD, 1'b1, C_NONE, "R7");
    step(C_NONE, 1'b0, C_NONE, "R7");
    for (int i = 0; i < 3; i++) step(C_NONE, 1'b0, C_LD, "R7");
    step(C_NONE, 1'b0, C_NONE, "R7");
    for (int i = 0; i < 3; i++) step(C_ALU, 1'b1, C_NONE, "R7");
    for (int i = 0; i < 3; i++) step(C_NONE, 1'b0, C_ALU, "R7");
    step(C_NONE, 1'b0, C_NONE, "R7");
  endtask

  task automatic t_load_after_alu();
    step(C_ALU,  1'b1, C_NONE, "R8");
    step(C_LD,   1'b1, C_NONE, "R8");
    step(C_NONE, 1'b0, C_NONE, "R8");
    step(C_NONE, 1'b0, C_ALU,  "R8");
    step(C_NONE, 1'b0, C_NONE, "R8");
    step(C_NONE, 1'b0, C_LD,   "R8");
    step(C_NONE, 1'b0, C_NONE, "R8");
  endtask

  // Mixed stream against a booking model built from R2/R3/R5/R9
  task automatic t_stream();
    logic [1:0] bk [0:7];
    logic [1:0] c;
    logic       hold;
    logic       ea;
    int         lat;
    for (int k = 0; k < 8; k++) bk[k] = C_NONE;
    hold = 1'b0;
    c    = C_NONE;
    for (int i = 0; i < 400; i++) begin
      if (!hold) begin
        case ($urandom_range(0, 5))
          0:       c = C_NONE;
          1:       c = C_RSV;
          2, 3:    c = C_LD;
          default: c = C_ALU;
        endcase
      end
      lat = (c == C_LD) ? 4 : 3;
      ea  = (c == C_ALU || c == C_LD) && (bk[lat] == C_NONE);
      step(c, ea, bk[0], "R5");
      hold = (c == C_ALU || c == C_LD) && !ea;
      if (ea) bk[lat] = c;
      for (int k = 0; k < 7; k++) bk[k] = bk[k + 1];
      bk[7] = C_NONE;
    end
    for (int i = 0; i < 6; i++) begin
      step(C_NONE, 1'b0, bk[0], "R9");
      for (int k = 0; k < 7; k++) bk[k] = bk[k + 1];
      bk[7] = C_NONE;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    req      = C_NONE;
    t_reset();
    t_alu_single();
    t_load_single();
    t_alu_after_load();
    t_ignored();
    t_back_to_back();
    t_load_after_alu();
    t_stream();
    summary();
  end

endmodule